// File: doc/BRIEF.md
# Interrupt Aggregation Controller

This block collects up to 32 external interrupt request lines into one pending summary that a processor reads over a simple register bus, and drives one combined interrupt output toward the CPU. Each line has its own synchronizer. Software can set each line to follow its input level or to latch an edge. Software can also set each line to active-high or active-low. Edge-latched requests stay set until software acknowledges them. To acknowledge, software writes a one to the line's bit in the clear register and then writes zero to that bit.

The pending summary passes through a board-dependent filter of valid bits before software sees it or it reaches the CPU output. The filter is a parameter, because boards differ in which lines are wired. Lines 20 to 30 are never connected, so they always read as zero. A floating input on those lines therefore cannot raise a request. Bit 31 is the cascade input from a legacy interrupt controller. Bits 0 to 19 carry expansion-slot lines, four per slot. When software writes one fixed key value to the reset register, the block emits a one-cycle system-reset request.

Top module: `irq_agg`

## Requirements
- R1: After reset, the mask, edge-select, polarity and clear registers all read 0, and `cpu_irq` and `sys_reset_req` are low.
- R2: The mask (offset 0x04), edge-select (0x08), polarity (0x0C) and clear (0x10) registers read back the last value written. Read data appears on `reg_rdata` on the clock after the read strobe. The reset register (0x14) and unmapped offsets read 0. Writes to the request register (0x00) are ignored.
- R3: A polarity bit of 1 makes the line active when its input is high. A polarity bit of 0 makes the line active when its input is low.
- R4: When a line's edge-select bit is 0, its request bit tracks the active state of the input after a two-flop synchronizer, and it drops when the input becomes inactive.
- R5: When a line's edge-select bit is 1, a change of the line from inactive to active sets a pending bit. That bit stays set after the input returns to inactive.
- R6: While a clear bit is 1, the edge pending bit of that line is held at 0 and new edges on the line are not recorded. Writing 0 to the clear bit re-arms the line. Level-mode lines are not affected by the clear register.
- R7: The request register (0x00) reads as pending bits AND the valid-bits parameter (default 0x800FFFFF). Bits 20 to 30 always read 0.
- R8: `cpu_irq` is the OR over all lines of pending AND mask AND valid-bits, where a mask bit of 1 enables its line.
- R9: `cpu_irq` is registered. It changes on the clock after the pending and mask state that cause the change.
- R10: Writing 0x0000DEAD to offset 0x14 raises `sys_reset_req` for exactly one cycle, starting on the clock after the write. Any other value written to that offset raises nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_lines | input | 32 | Raw interrupt request inputs, asynchronous |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid on the clock after the read strobe |
| cpu_irq | output | 1 | Combined interrupt to the processor |
| sys_reset_req | output | 1 | One-cycle system-reset request |

## Verification
On every cycle, the assertions check the following:
- The reset request is one cycle wide and is always caused by a key write.
- The CPU output equals last cycle's masked pending state.
- An edge pending bit never drops unless its clear bit was set.
- No line is recorded while its clear bit is held.
- Unconnected bits never show in a request read.
- Mask reads return the stored value.

Only the bench scenarios can show the following:
- Polarity and level tracking across many input patterns.
- The full write-one-then-zero acknowledge sequence, with its re-arming.
- The exact synchronizer delay.
- Key-value rejection.

// File: rtl/irq_agg_pkg.sv
// Package irq_agg_pkg
// Shared register offsets, the reset key value and the register decode type
// for the interrupt aggregation controller.
package irq_agg_pkg;

    localparam logic [15:0] OFS_REQ  = 16'h0000;
    localparam logic [15:0] OFS_MASK = 16'h0004;
    localparam logic [15:0] OFS_EDGE = 16'h0008;
    localparam logic [15:0] OFS_POL  = 16'h000C;
    localparam logic [15:0] OFS_CLR  = 16'h0010;
    localparam logic [15:0] OFS_RST  = 16'h0014;

    localparam logic [31:0] RESET_KEY = 32'h0000_DEAD;

    typedef enum logic [2:0] {
        SEL_REQ,
        SEL_MASK,
        SEL_EDGE,
        SEL_POL,
        SEL_CLR,
        SEL_RST,
        SEL_NONE
    } reg_sel_e;

    // Map a byte offset onto a register selector.
    function automatic reg_sel_e decode_offset(input logic [15:0] ofs);
        case (ofs)
            OFS_REQ:  return SEL_REQ;
            OFS_MASK: return SEL_MASK;
            OFS_EDGE: return SEL_EDGE;
            OFS_POL:  return SEL_POL;
            OFS_CLR:  return SEL_CLR;
            OFS_RST:  return SEL_RST;
            default:  return SEL_NONE;
        endcase
    endfunction

    // Build a mask with ones from bit lo to bit hi, inclusive.
    function automatic logic [63:0] span_mask(input int lo, input int hi);
        logic [63:0] m;
        m = '0;
        for (int i = 0; i < 64; i++) begin
            if (i >= lo && i <= hi) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/irq_agg_line.sv
// Module irq_agg_line
// Conditioning logic for one interrupt line. It synchronizes the raw input,
// applies the polarity, and produces either a level request or a sticky edge
// request.
// Assumes: SYNC_STAGES >= 2; irq_raw may be asynchronous to clk.
module irq_agg_line #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_raw,
    input  logic edge_mode,
    input  logic act_high,
    input  logic clr_hold,
    output logic pend,
    output logic sticky_q
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   active;
    logic                   prev_act_q;
    logic                   rise;

    // Bring the raw input into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], irq_raw};
    end

    // Apply polarity and find inactive-to-active transitions.
    always_comb begin
        active = act_high ? sync_q[SYNC_STAGES-1] : ~sync_q[SYNC_STAGES-1];
        rise   = active & ~prev_act_q;
    end

    // Remember last cycle's active state for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_act_q <= 1'b0;
        else        prev_act_q <= active;
    end

    // Latch edges until acknowledged; the clear bit dominates new edges.
    always_ff @(posedge clk) begin
        if (!rst_n)         sticky_q <= 1'b0;
        else if (!edge_mode) sticky_q <= 1'b0;
        else                 sticky_q <= (sticky_q | rise) & ~clr_hold;
    end

    // Select the request reported for this line.
    always_comb begin
        pend = edge_mode ? sticky_q : active;
    end

endmodule

// File: rtl/irq_agg_regs.sv
// Module irq_agg_regs
// Register file of the controller. It decodes writes, returns reads with one
// cycle of latency and produces the reset-request pulse on a key write.
// Assumes: single-cycle write and read strobes; they are never both asserted
// toward the same register in the same cycle in a way that needs ordering.
module irq_agg_regs
    import irq_agg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] req_view,
    output logic [DATA_W-1:0] mask_q,
    output logic [DATA_W-1:0] edge_q,
    output logic [DATA_W-1:0] pol_q,
    output logic [DATA_W-1:0] clr_q,
    output logic [DATA_W-1:0] rdata,
    output logic              rst_pulse
);

    localparam logic [DATA_W-1:0] KEY = DATA_W'(RESET_KEY);

    reg_sel_e sel;

    // Decode the offset once for both paths.
    always_comb begin
        sel = decode_offset(16'(addr));
    end

    // Update the writable control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            edge_q <= '0;
            pol_q  <= '0;
            clr_q  <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_MASK: mask_q <= wdata;
                SEL_EDGE: edge_q <= wdata;
                SEL_POL:  pol_q  <= wdata;
                SEL_CLR:  clr_q  <= wdata;
                default:  ;
            endcase
        end
    end

    // Return read data one cycle after the strobe; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            case (sel)
                SEL_REQ:  rdata <= req_view;
                SEL_MASK: rdata <= mask_q;
                SEL_EDGE: rdata <= edge_q;
                SEL_POL:  rdata <= pol_q;
                SEL_CLR:  rdata <= clr_q;
                default:  rdata <= '0;
            endcase
        end
    end

    // Pulse the reset request for one cycle on a key write.
    always_ff @(posedge clk) begin
        if (!rst_n) rst_pulse <= 1'b0;
        else        rst_pulse <= wr_en && (sel == SEL_RST) && (wdata == KEY);
    end

endmodule

// File: rtl/irq_agg.sv
// Module irq_agg (top)
// Interrupt aggregation controller. It holds one conditioning slice per line,
// the register file, the valid-bits filter and the registered CPU output.
// Assumes: NUM_LINES equals the register data width; lines NC_LO..NC_HI are
// unconnected on every board and always report zero.
module irq_agg
    import irq_agg_pkg::*;
#(
    parameter int                 NUM_LINES   = 32,
    parameter int                 ADDR_W      = 8,
    parameter int                 SYNC_STAGES = 2,
    parameter int                 NC_LO       = 20,
    parameter int                 NC_HI       = 30,
    parameter logic [NUM_LINES-1:0] VALID_BITS = 32'h800F_FFFF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_lines,
    input  logic                 reg_wr_en,
    input  logic                 reg_rd_en,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [NUM_LINES-1:0] reg_wdata,
    output logic [NUM_LINES-1:0] reg_rdata,
    output logic                 cpu_irq,
    output logic                 sys_reset_req
);

    localparam logic [NUM_LINES-1:0] NC_MASK   = NUM_LINES'(span_mask(NC_LO, NC_HI));
    localparam logic [NUM_LINES-1:0] VALID_EFF = VALID_BITS & ~NC_MASK;

    logic [NUM_LINES-1:0] mask_q;
    logic [NUM_LINES-1:0] edge_q;
    logic [NUM_LINES-1:0] pol_q;
    logic [NUM_LINES-1:0] clr_q;
    logic [NUM_LINES-1:0] pend_vec;
    logic [NUM_LINES-1:0] sticky_vec;
    logic [NUM_LINES-1:0] req_view;

    // One conditioning slice per interrupt line.
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        irq_agg_line #(
            .SYNC_STAGES(SYNC_STAGES)
        ) u_line (
            .clk      (clk),
            .rst_n    (rst_n),
            .irq_raw  (irq_lines[g]),
            .edge_mode(edge_q[g]),
            .act_high (pol_q[g]),
            .clr_hold (clr_q[g]),
            .pend     (pend_vec[g]),
            .sticky_q (sticky_vec[g])
        );
    end

    // Filter the pending set down to wired lines.
    always_comb begin
        req_view = pend_vec & VALID_EFF;
    end

    irq_agg_regs #(
        .DATA_W(NUM_LINES),
        .ADDR_W(ADDR_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .rd_en    (reg_rd_en),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .req_view (req_view),
        .mask_q   (mask_q),
        .edge_q   (edge_q),
        .pol_q    (pol_q),
        .clr_q    (clr_q),
        .rdata    (reg_rdata),
        .rst_pulse(sys_reset_req)
    );

    // Register the combined, enabled request toward the CPU.
    always_ff @(posedge clk) begin
        if (!rst_n) cpu_irq <= 1'b0;
        else        cpu_irq <= |(req_view & mask_q);
    end

endmodule

// File: rtl/irq_agg_chk.sv
// Module irq_agg_chk
// Checker bound into irq_agg. It watches the ports and the state handed
// between the line slices and the register file.
// Assumes: connected through the bind below.
module irq_agg_chk
    import irq_agg_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int ADDR_W    = 8,
    parameter int NC_LO     = 20,
    parameter int NC_HI     = 30
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 reg_wr_en,
    input logic                 reg_rd_en,
    input logic [ADDR_W-1:0]    reg_addr,
    input logic [NUM_LINES-1:0] reg_wdata,
    input logic [NUM_LINES-1:0] reg_rdata,
    input logic                 cpu_irq,
    input logic                 sys_reset_req,
    input logic [NUM_LINES-1:0] req_view,
    input logic [NUM_LINES-1:0] mask_q,
    input logic [NUM_LINES-1:0] edge_q,
    input logic [NUM_LINES-1:0] clr_q,
    input logic [NUM_LINES-1:0] sticky_vec
);

    localparam logic [NUM_LINES-1:0] NC_MASK = NUM_LINES'(span_mask(NC_LO, NC_HI));

    assert_rst_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_req |=> !sys_reset_req);

    assert_rst_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_req |-> $past(reg_wr_en && (16'(reg_addr) == OFS_RST)
                                && (reg_wdata == NUM_LINES'(RESET_KEY))));

    assert_irq_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq == $past(|(req_view & mask_q)));

    assert_sticky_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sticky_vec & edge_q & ~clr_q) & ~sticky_vec) == '0);

    assert_clear_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clr_q) & sticky_vec) == '0);

    assert_nc_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_en && (16'(reg_addr) == OFS_REQ)) |=> ((reg_rdata & NC_MASK) == '0));

    assert_mask_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_en && (16'(reg_addr) == OFS_MASK)) |=> (reg_rdata == $past(mask_q)));

endmodule

bind irq_agg irq_agg_chk #(
    .NUM_LINES(NUM_LINES),
    .ADDR_W   (ADDR_W),
    .NC_LO    (NC_LO),
    .NC_HI    (NC_HI)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr_en    (reg_wr_en),
    .reg_rd_en    (reg_rd_en),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .cpu_irq      (cpu_irq),
    .sys_reset_req(sys_reset_req),
    .req_view     (req_view),
    .mask_q       (mask_q),
    .edge_q       (edge_q),
    .clr_q        (clr_q),
    .sticky_vec   (sticky_vec)
);

// File: tb/irq_agg_test.sv
// Bench for irq_agg. Inputs are driven on falling edges and outputs are
// sampled on falling edges. Expected values are computed from the requirements.
module irq_agg_test;

    localparam logic [31:0] VALID = 32'h800F_FFFF;
    localparam logic [31:0] NC    = 32'h7FF0_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_lines = '0;
    logic        reg_wr_en = 1'b0;
    logic        reg_rd_en = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cpu_irq;
    logic        sys_reset_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_agg uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .irq_lines    (irq_lines),
        .reg_wr_en    (reg_wr_en),
        .reg_rd_en    (reg_rd_en),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .cpu_irq      (cpu_irq),
        .sys_reset_req(sys_reset_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd_en = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd_en = 1'b0;
        d = reg_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_line(input int n);
        @(negedge clk);
        irq_lines[n] = 1'b1;
        repeat (2) @(negedge clk);
        irq_lines[n] = 1'b0;
        settle();
    endtask

    function automatic logic [31:0] level_exp(input logic [31:0] in, input logic [31:0] pol);
        return ~(in ^ pol) & VALID;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        logic [31:0] pols [4];
        pols[0] = 32'h8000_0000; pols[1] = 32'hFFFF_FFFF;
        pols[2] = 32'h0000_0000; pols[3] = 32'h0F0F_0F0F;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 cpu_irq", {31'b0, cpu_irq}, 32'h0);
        check("R1 sys_reset_req", {31'b0, sys_reset_req}, 32'h0);
        rd(8'h04, d); check("R1 mask", d, 32'h0);
        rd(8'h08, d); check("R1 edge", d, 32'h0);
        rd(8'h0C, d); check("R1 pol", d, 32'h0);
        rd(8'h10, d); check("R1 clear", d, 32'h0);

        // R2: readback, reset and unmapped offsets, request is read-only
        wr(8'h04, 32'h1234_5678); rd(8'h04, d); check("R2 mask rb", d, 32'h1234_5678);
        wr(8'h08, 32'hCAFE_F00D); rd(8'h08, d); check("R2 edge rb", d, 32'hCAFE_F00D);
        wr(8'h0C, 32'h8765_4321); rd(8'h0C, d); check("R2 pol rb", d, 32'h8765_4321);
        wr(8'h10, 32'h0F0F_00F0); rd(8'h10, d); check("R2 clear rb", d, 32'h0F0F_00F0);
        rd(8'h14, d); check("R2 reset reads 0", d, 32'h0);
        rd(8'h20, d); check("R2 unmapped reads 0", d, 32'h0);
        wr(8'h00, 32'hFFFF_FFFF); rd(8'h04, d); check("R2 req write ignored", d, 32'h1234_5678);
        wr(8'h10, 32'h0); wr(8'h04, 32'h0); wr(8'h08, 32'h0);

        // R3 R4 R7: level sweep over patterns and polarities
        for (int p = 0; p < 4; p++) begin
            wr(8'h0C, pols[p]);
            for (int k = 0; k < 20; k++) begin
                logic [31:0] pat;
                pat = (k == 0) ? 32'h0 : (k == 1) ? 32'hFFFF_FFFF : 32'(k) * 32'h9E37_79B9;
                @(negedge clk);
                irq_lines = pat;
                settle();
                rd(8'h00, d);
                check("R3 R4 R7 level request", d, level_exp(pat, pols[p]));
                check("R7 unconnected zero", d & NC, 32'h0);
            end
        end

        // R4: level request drops when the input goes inactive
        wr(8'h0C, 32'hFFFF_FFFF);
        @(negedge clk); irq_lines = 32'h0000_0008; settle();
        rd(8'h00, d); check("R4 level high", d, 32'h0000_0008);
        @(negedge clk); irq_lines = 32'h0; settle();
        rd(8'h00, d); check("R4 level drop", d, 32'h0);

        // R8: walking mask against a single active line
        for (int i = 0; i < 32; i++) begin
            wr(8'h04, 32'h1 << i);
            @(negedge clk); irq_lines = 32'h1 << i; settle();
            check("R8 walking mask", {31'b0, cpu_irq}, {31'b0, VALID[i]});
            wr(8'h04, ~(32'h1 << i));
            settle();
            check("R8 masked off", {31'b0, cpu_irq}, 32'h0);
            @(negedge clk); irq_lines = 32'h0;
        end
        wr(8'h04, 32'h0); settle();

        // R9: exact latency, line 0 level active-high, mask only line 0
        wr(8'h04, 32'h1); settle();
        check("R9 idle", {31'b0, cpu_irq}, 32'h0);
        @(negedge clk); irq_lines = 32'h1;
        repeat (2) @(negedge clk);
        check("R9 not yet", {31'b0, cpu_irq}, 32'h0);
        @(negedge clk);
        check("R9 one clock after pending", {31'b0, cpu_irq}, 32'h1);
        @(negedge clk); irq_lines = 32'h0;
        wr(8'h04, 32'h0); settle();

        // R5 R6: edge latching and the write-one-then-zero acknowledge
        wr(8'h08, 32'hFFFF_FFFF); settle();
        rd(8'h00, d); check("R5 edge idle", d, 32'h0);
        pulse_line(5);
        rd(8'h00, d); check("R5 sticky after pulse", d, 32'h0000_0020);
        pulse_line(25);
        rd(8'h00, d); check("R7 edge on unconnected", d, 32'h0000_0020);
        wr(8'h10, 32'h0000_0020);
        rd(8'h00, d); check("R6 clear removes", d, 32'h0);
        pulse_line(5);
        rd(8'h00, d); check("R6 edge ignored while clear held", d, 32'h0);
        wr(8'h10, 32'h0);
        rd(8'h00, d); check("R6 still clear after zero write", d, 32'h0);
        pulse_line(5);
        rd(8'h00, d); check("R6 re-armed", d, 32'h0000_0020);
        wr(8'h04, 32'h0000_0020); settle();
        check("R8 edge pending drives cpu_irq", {31'b0, cpu_irq}, 32'h1);
        wr(8'h10, 32'h0000_0020); wr(8'h10, 32'h0); settle();
        check("R6 cpu_irq drops after ack", {31'b0, cpu_irq}, 32'h0);

        // R6: level lines unaffected by clear
        wr(8'h08, 32'h0);
        @(negedge clk); irq_lines = 32'h0000_0008; settle();
        wr(8'h10, 32'h0000_0008); settle();
        rd(8'h00, d); check("R6 level ignores clear", d, 32'h0000_0008);
        wr(8'h10, 32'h0);
        @(negedge clk); irq_lines = 32'h0;

        // R10: key write pulses one cycle; other values do nothing
        wr(8'h14, 32'h0000_DEAD);
        check("R10 pulse high", {31'b0, sys_reset_req}, 32'h1);
        @(negedge clk);
        check("R10 pulse one cycle", {31'b0, sys_reset_req}, 32'h0);
        wr(8'h14, 32'h0000_DEAE);
        check("R10 wrong key", {31'b0, sys_reset_req}, 32'h0);
        wr(8'h10, 32'h0000_DEAD);
        check("R10 key at other offset", {31'b0, sys_reset_req}, 32'h0);

        finish_run();
    end

endmodule